// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures the frequency of one clock taken from a bank of internal clock inputs. Software selects a source by numeric index and picks a gate length. It then writes the control word with both the enable and the run bit set. The unit opens a gate window of a known number of reference-clock cycles and counts rising edges of the chosen clock in that clock's own domain. When the window closes, the count crosses back into the reference domain through a toggle handshake. The result register then holds the count together with an overflow flag, and the busy flag drops.

Inputs that are not populated, and indices beyond the bank, contribute no clock. Such a measurement finishes through a drain timeout and posts a count of zero. The counter saturates instead of wrapping and raises the overflow flag. Software can therefore start with a long gate and step the gate length down until the flag stays clear, which gives the best precision the counter allows.

Registers are 32 bits wide and sit at a 4-byte stride. The control word is at offset 0x0 and the read-only result is at offset 0x4.

Top module: `fmeter`

## Requirements
- R1: After reset, both the control word (offset 0x0) and the result word (offset 0x4) read 0.
- R2: A write to offset 0x0 starts a measurement only when the unit is idle and the write sets both bit 16 (enable) and bit 17 (run). Busy (control bit 31) then reads 1 from the next cycle on. A write that sets only one of those two bits leaves busy at 0 and still stores the other fields.
- R3: The gate window lasts BASE_CYCLES << G reference cycles, where G is control bits 11:8. The source is selected by control bits 6:0. The count in result bits CNT_W-1:0 equals the number of rising edges of the selected clock in that window, to within ±1.
- R4: Busy stays 1 until the count has been handed over. The result word changes only in the cycle in which busy falls.
- R5: An index at or above NUM_SRC, or one whose SRC_PRESENT bit is 0, yields a result of 0 with no overflow, even if that input toggles.
- R6: When the edge count exceeds 2^CNT_W-1, the result holds all ones in its count field and sets bit 31 (overflow). A shorter gate on the same clock then gives a result with bit 31 clear.
- R7: A write of all zeros to offset 0x0 clears the control word, drops busy in the next cycle and abandons the measurement in progress without touching the result. A later measurement then works normally.
- R8: Once the unit is idle, a write to offset 0x0 with bit 16 clear leaves the unit disabled (bit 16 reads 0, busy 0) and does not change the result.
- R9: While busy, any write of a non-zero word to offset 0x0 is ignored. The control fields keep their values and the running measurement completes on the original source.
- R10: Writes to offset 0x4 have no effect on the result word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock that times the gate and runs the register interface |
| rst_n | input | 1 | Synchronous active-low reset |
| src_clks | input | NUM_SRC | Bank of clocks that can be measured, one per index |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The main function is tried on sources of 2, 6, 8, 10, 12, 16 and 40 ns period against gate lengths 2 to 4. Whole-number and fractional edge counts are both covered, so a window that is one reference cycle off or a lost edge shows up. A 2 ns clock is measured at gates 6 and 4, which separates saturation from plain counting. A toggling but unpopulated input and an out-of-range index separate the population mask from the index range check. Aborting a slow measurement and then measuring a different clock shows whether a late handshake toggle from the abandoned run is wrongly accepted.

// File: rtl/fm_pkg.sv
// Shared constants and types for the gated clock frequency meter.
// Assumes a 32-bit register file at a 4-byte stride.
package fm_pkg;
    localparam int REG_W    = 32;
    localparam int ADDR_W   = 4;
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_RESULT = 4'h4;

    // control word layout
    localparam int SEL_LSB  = 0;
    localparam int SEL_W    = 7;
    localparam int GATE_LSB = 8;
    localparam int GATE_W   = 4;
    localparam int EN_BIT   = 16;
    localparam int RUN_BIT  = 17;
    localparam int BUSY_BIT = 31;
    // result word layout
    localparam int OVF_BIT  = 31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_DRAIN = 2'd2
    } fm_state_e;
endpackage

// File: rtl/fm_src_mux.sv
// Picks one clock out of the source bank by numeric index.
// Unpopulated inputs and out-of-range indices give a constant 0.
// Assumes the index changes only while no measurement is running.
module fm_src_mux #(
    parameter int NUM_SRC = 8,
    parameter logic [NUM_SRC-1:0] SRC_PRESENT = '1
) (
    input  logic [NUM_SRC-1:0]      src_clks,
    input  logic [fm_pkg::SEL_W-1:0] sel,
    output logic                    meas_clk
);
    logic [NUM_SRC-1:0] gated;

    // one AND term per populated source, forced low otherwise
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (SRC_PRESENT[i]) begin : g_pop
            assign gated[i] = src_clks[i] & (sel == fm_pkg::SEL_W'(i));
        end else begin : g_gap
            assign gated[i] = 1'b0;
        end
    end

    assign meas_clk = |gated;
endmodule

// File: rtl/fm_edge_cnt.sv
// Counts rising edges of the measured clock while the synchronised gate
// is high, saturating at all ones with a sticky overflow flag.
// When the gate closes it flips done_tgl; the count is stable from then on.
// Assumes the measured clock toggles during reset for a clean start.
module fm_edge_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             meas_clk,
    input  logic             rst_n,
    input  logic             gate_ref,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             done_tgl
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic g1, g2, g3;

    // bring the gate into the measured domain and keep one delayed copy
    always_ff @(posedge meas_clk) begin
        if (!rst_n) begin
            g1 <= 1'b0;
            g2 <= 1'b0;
            g3 <= 1'b0;
        end else begin
            g1 <= gate_ref;
            g2 <= g1;
            g3 <= g2;
        end
    end

    // count edges seen with the gate open, saturating on overflow
    always_ff @(posedge meas_clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else if (g2 && !g3) begin
            count <= CNT_W'(1);
            ovf   <= 1'b0;
        end else if (g2) begin
            if (count == CNT_MAX) ovf <= 1'b1;
            else                  count <= count + CNT_W'(1);
        end
    end

    // announce a closed window by flipping the toggle once
    always_ff @(posedge meas_clk) begin
        if (!rst_n)          done_tgl <= 1'b0;
        else if (!g2 && g3)  done_tgl <= ~done_tgl;
    end
endmodule

// File: rtl/fm_ctrl.sv
// Reference-domain side: register file, gate timer, measurement FSM and
// receive side of the toggle handshake with a drain timeout.
// Assumes DRAIN_CYCLES exceeds three periods of the slowest source plus
// three reference cycles, and that a new start follows an abort by at
// least that long.
module fm_ctrl #(
    parameter int CNT_W        = 16,
    parameter int BASE_CYCLES  = 16,
    parameter int DRAIN_CYCLES = 64
) (
    input  logic                         clk_ref,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [fm_pkg::ADDR_W-1:0]    bus_addr,
    input  logic [fm_pkg::REG_W-1:0]     bus_wdata,
    output logic [fm_pkg::REG_W-1:0]     bus_rdata,
    output logic [fm_pkg::SEL_W-1:0]     sel,
    output logic                         gate_ref,
    output logic                         busy,
    output logic [fm_pkg::REG_W-1:0]     result_word,
    input  logic [CNT_W-1:0]             cnt_in,
    input  logic                         ovf_in,
    input  logic                         tgl_in
);
    import fm_pkg::*;

    localparam int TMR_W = $clog2(BASE_CYCLES) + (1 << GATE_W);
    localparam int DRN_W = $clog2(DRAIN_CYCLES);
    localparam int PAD_W = REG_W - 1 - CNT_W;

    fm_state_e          state;
    logic [GATE_W-1:0]  gate_q;
    logic               en_q;
    logic [TMR_W-1:0]   tmr;
    logic [DRN_W-1:0]   drn;
    logic [CNT_W-1:0]   res_cnt;
    logic               res_ovf;
    logic               t1, t2, t3;
    logic               ack;
    logic               wr_ctrl, wr_zero, start_req;
    logic [GATE_W-1:0]  wgate;

    // window length minus one for a given gate field
    function automatic logic [TMR_W-1:0] win_m1(input logic [GATE_W-1:0] g);
        return (TMR_W'(BASE_CYCLES) << g) - TMR_W'(1);
    endfunction

    assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_zero   = wr_ctrl && (bus_wdata == '0);
    assign start_req = wr_ctrl && bus_wdata[EN_BIT] && bus_wdata[RUN_BIT];
    assign wgate     = bus_wdata[GATE_LSB +: GATE_W];
    assign busy      = (state != ST_IDLE);

    // synchronise the completion toggle and flag each change
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            t1 <= 1'b0;
            t2 <= 1'b0;
            t3 <= 1'b0;
        end else begin
            t1 <= tgl_in;
            t2 <= t1;
            t3 <= t2;
        end
    end
    assign ack = t2 ^ t3;

    // measurement FSM with register writes and result capture
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            sel      <= '0;
            gate_q   <= '0;
            en_q     <= 1'b0;
            gate_ref <= 1'b0;
            tmr      <= '0;
            drn      <= '0;
            res_cnt  <= '0;
            res_ovf  <= 1'b0;
        end else if (wr_zero) begin
            state    <= ST_IDLE;
            sel      <= '0;
            gate_q   <= '0;
            en_q     <= 1'b0;
            gate_ref <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (wr_ctrl) begin
                        sel    <= bus_wdata[SEL_LSB +: SEL_W];
                        gate_q <= wgate;
                        en_q   <= bus_wdata[EN_BIT];
                        if (start_req) begin
                            state    <= ST_GATE;
                            tmr      <= win_m1(wgate);
                            gate_ref <= 1'b1;
                        end
                    end
                end
                ST_GATE: begin
                    if (tmr == '0) begin
                        gate_ref <= 1'b0;
                        drn      <= '0;
                        state    <= ST_DRAIN;
                    end else begin
                        tmr <= tmr - TMR_W'(1);
                    end
                end
                ST_DRAIN: begin
                    if (ack) begin
                        res_cnt <= cnt_in;
                        res_ovf <= ovf_in;
                        state   <= ST_IDLE;
                    end else if (drn == DRN_W'(DRAIN_CYCLES - 1)) begin
                        res_cnt <= '0;
                        res_ovf <= 1'b0;
                        state   <= ST_IDLE;
                    end else begin
                        drn <= drn + DRN_W'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result_word = {res_ovf, {PAD_W{1'b0}}, res_cnt};

    // register read decode
    always_comb begin
        case (bus_addr)
            OFS_CTRL:   bus_rdata = {busy, 13'd0, 1'b0, en_q, 4'd0, gate_q, 1'b0, sel};
            OFS_RESULT: bus_rdata = result_word;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/fmeter.sv
// Top of the gated clock frequency meter: source mux, edge counter in the
// measured domain and reference-domain control. Bound checker below.
module fmeter #(
    parameter int NUM_SRC      = 8,
    parameter logic [NUM_SRC-1:0] SRC_PRESENT = '1,
    parameter int CNT_W        = 16,
    parameter int BASE_CYCLES  = 16,
    parameter int DRAIN_CYCLES = 64
) (
    input  logic                clk_ref,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_clks,
    input  logic                bus_wr,
    input  logic [3:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata
);
    logic [fm_pkg::SEL_W-1:0] sel;
    logic                     meas_clk;
    logic                     gate_ref;
    logic                     busy;
    logic [31:0]              result_word;
    logic [CNT_W-1:0]         cnt;
    logic                     ovf;
    logic                     done_tgl;

    fm_src_mux #(.NUM_SRC(NUM_SRC), .SRC_PRESENT(SRC_PRESENT)) u_mux (
        .src_clks (src_clks),
        .sel      (sel),
        .meas_clk (meas_clk)
    );

    fm_edge_cnt #(.CNT_W(CNT_W)) u_cnt (
        .meas_clk (meas_clk),
        .rst_n    (rst_n),
        .gate_ref (gate_ref),
        .count    (cnt),
        .ovf      (ovf),
        .done_tgl (done_tgl)
    );

    fm_ctrl #(
        .CNT_W        (CNT_W),
        .BASE_CYCLES  (BASE_CYCLES),
        .DRAIN_CYCLES (DRAIN_CYCLES)
    ) u_ctrl (
        .clk_ref     (clk_ref),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .sel         (sel),
        .gate_ref    (gate_ref),
        .busy        (busy),
        .result_word (result_word),
        .cnt_in      (cnt),
        .ovf_in      (ovf),
        .tgl_in      (done_tgl)
    );
endmodule

// File: rtl/fmeter_chk.sv
// Property checker for fmeter, attached by bind. Observes the register
// interface, the busy flag and the stored result word.
module fmeter_chk #(
    parameter int CNT_W = 16
) (
    input logic        clk_ref,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [3:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        busy,
    input logic [31:0] result_word
);
    // R7
    abort_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h0 && bus_wdata == 32'd0) |=> !busy);

    // R2
    start_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h0 && bus_wdata[16] && bus_wdata[17] && !busy) |=> busy);

    // R4
    result_hold_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!$stable(result_word)) |-> $fell(busy));

    // R6
    saturate_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        result_word[31] |-> (result_word[CNT_W-1:0] == {CNT_W{1'b1}}));

    // R10
    read_only_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (bus_wr && bus_addr == 4'h4 && !busy) |=> $stable(result_word));
endmodule

bind fmeter fmeter_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_ref     (clk_ref),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .busy        (busy),
    .result_word (result_word)
);

// File: tb/tb_fmeter.sv
`timescale 1ns/1ps
module tb_fmeter;
    localparam int NUM_SRC = 8;
    localparam int CNT_W   = 10;
    localparam int BASE    = 16;
    localparam int REF_NS  = 4;
    // source periods in ps; index 6 toggles but is unpopulated
    localparam int PER_PS [NUM_SRC] = '{8000, 10000, 16000, 6000, 40000, 2000, 5000, 12000};
    // stimulus table: source index and gate field, expected count computed
    localparam int NV = 7;
    localparam int V_SRC  [NV] = '{0, 1, 2, 3, 4, 7, 5};
    localparam int V_GATE [NV] = '{2, 2, 3, 2, 3, 2, 4};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    wire  [NUM_SRC-1:0] src_clks;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;

    int n_checks = 0;
    int n_errors = 0;

    always #2 clk = ~clk;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_clk
        logic c = 1'b0;
        initial forever #(PER_PS[i] / 2000.0) c = ~c;
        assign src_clks[i] = c;
    end

    fmeter #(
        .NUM_SRC(NUM_SRC), .SRC_PRESENT(8'hBF), .CNT_W(CNT_W),
        .BASE_CYCLES(BASE), .DRAIN_CYCLES(64)
    ) dut (
        .clk_ref(clk), .rst_n(rst_n), .src_clks(src_clks),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = 32'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input int src, input int g, input bit en, input bit run);
        return 32'(src) | (32'(g) << 8) | (32'(en) << 16) | (32'(run) << 17);
    endfunction

    task automatic wait_idle();
        logic [31:0] d;
        for (int k = 0; k < 3000; k++) begin
            rd(4'h0, d);
            if (!d[31]) return;
        end
    endtask

    task automatic measure(input int src, input int g, output logic [31:0] res);
        logic [31:0] d;
        wr(4'h0, ctrl_word(src, g, 1'b1, 1'b1));
        rd(4'h0, d);
        check(d[31] == 1'b1, "R2 busy after start", d[31], 1);
        wait_idle();
        rd(4'h4, res);
    endtask

    task automatic check_count(input string req, input int src, input int g, input logic [31:0] res);
        real e;
        real diff;
        e = real'(REF_NS * (BASE << g)) * 1000.0 / real'(PER_PS[src]);
        diff = real'(res[CNT_W-1:0]) - e;
        if (diff < 0.0) diff = -diff;
        check(diff <= 1.5 && !res[31], req, res, longint'(e));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] res;
        logic [31:0] prev;

        repeat (10) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        rd(4'h0, d); check(d == 32'd0, "R1 ctrl after reset", d, 0);
        rd(4'h4, d); check(d == 32'd0, "R1 result after reset", d, 0);

        // R2: one of the two start bits is not enough
        wr(4'h0, ctrl_word(0, 2, 1'b1, 1'b0));
        rd(4'h0, d); check(d == ctrl_word(0, 2, 1'b1, 1'b0), "R2 enable only, no busy", d, ctrl_word(0, 2, 1'b1, 1'b0));
        wr(4'h0, ctrl_word(0, 2, 1'b0, 1'b1));
        rd(4'h0, d); check(d[31] == 1'b0, "R2 run only, no busy", d[31], 0);

        // R3: walk the stimulus table
        for (int v = 0; v < NV; v++) begin
            measure(V_SRC[v], V_GATE[v], res);
            check_count("R3 count in window", V_SRC[v], V_GATE[v], res);
        end

        // R5: unpopulated input (toggling) and out-of-range index
        measure(6, 2, res); check(res == 32'd0, "R5 unpopulated source", res, 0);
        measure(0, 2, res);
        measure(9, 2, res); check(res == 32'd0, "R5 index beyond bank", res, 0);

        // R6: saturation, then a shorter gate clears it
        measure(5, 6, res); check(res == 32'h8000_03FF, "R6 saturated count", res, 32'h8000_03FF);
        prev = res;
        measure(5, 4, res); check_count("R6 shorter gate no overflow", 5, 4, res);
        prev = res;

        // R8: disable after completion keeps the result
        wr(4'h0, ctrl_word(5, 4, 1'b0, 1'b0));
        rd(4'h0, d); check(d[16] == 1'b0 && d[31] == 1'b0, "R8 disabled and idle", d, ctrl_word(5, 4, 1'b0, 1'b0));
        rd(4'h4, d); check(d == prev, "R8 result kept", d, prev);

        // R10: result is read-only
        wr(4'h4, 32'hFFFF_FFFF);
        rd(4'h4, d); check(d == prev, "R10 write to result ignored", d, prev);

        // R9: writes while busy are ignored
        wr(4'h0, ctrl_word(0, 2, 1'b1, 1'b1));
        wr(4'h0, ctrl_word(4, 3, 1'b1, 1'b1));
        rd(4'h0, d); check(d == (ctrl_word(0, 2, 1'b1, 1'b0) | 32'h8000_0000), "R9 fields unchanged while busy", d, ctrl_word(0, 2, 1'b1, 1'b0) | 32'h8000_0000);
        wait_idle();
        rd(4'h4, res); check_count("R9 original source measured", 0, 2, res);
        prev = res;

        // R7: abort a slow measurement, then measure again
        wr(4'h0, ctrl_word(4, 3, 1'b1, 1'b1));
        repeat (20) @(negedge clk);
        wr(4'h0, 32'd0);
        rd(4'h0, d); check(d == 32'd0, "R7 ctrl cleared and idle", d, 0);
        rd(4'h4, d); check(d == prev, "R7 result untouched by abort", d, prev);
        repeat (80) @(negedge clk);
        measure(2, 2, res); check_count("R7 measurement after abort", 2, 2, res);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule